// File: doc/BRIEF.md
# Dual-Issue Scoreboard Issue Stage

This block sits between decode and the execution units of a two-wide in-order core. A pair of decoded instructions comes in over a ready/valid handshake. The first slot (A) is the older instruction and the second slot (B) is the younger. Each instruction names an execution class, an optional destination register and up to two optional source registers. The pair is held in two slot registers. On every clock the stage decides which pending slots may start execution.

A table of per-register busy bits tracks results that are still in flight. Issuing a writer marks its destination busy. A busy bit is cleared only when one of the two writeback ports names that register. A slot that reads a busy register, or writes one, waits in its slot and is tried again on the next clock. Inside a pair, the younger instruction goes together with the older one only when the two use different execution classes and the younger does not touch the older one's destination. Issue never runs ahead of program order.

The stage accepts the next pair in the same cycle in which the last pending slot issues. A stream without hazards therefore flows at two instructions per clock.

Top module: `dual_issue_sb`

## Requirements
- R1: Unit codes are 0 integer, 1 floating point and 2 branch. A pending pair whose slots use different codes and have no hazards issues both slots in the same clock.
- R2: When both pending slots use the same unit code, only slot A issues. Slot B issues on the following clock if it has no other hazard.
- R3: Issuing an instruction that writes a register other than 0 sets that register's busy bit. The bit stays set until a writeback port presents that register number. Once the writeback is presented, a reader of the register may issue from the next clock on.
- R4: A slot with a busy enabled source is held and tried again on every clock. It issues, with its unit, write flag and destination on the issue outputs, in the first clock in which no hazard remains.
- R5: Slot B does not issue in the same clock as slot A when B reads A's destination or writes the same destination, provided A writes a register other than 0.
- R6: Issue is in order. While slot A is pending and held, slot B does not issue, even when B is free of hazards.
- R7: Register 0 is never busy. Reading it or writing it causes no hold.
- R8: When a writeback clears a register in the same clock that a new writer of that register issues, the register ends up busy.
- R9: A slot whose destination (not register 0) is busy is held until that register is written back.
- R10: in_ready is high exactly when every pending slot issues in the current clock. A pair is taken on in_valid and in_ready. A slot whose valid flag is low when the pair is taken never issues.
- R11: After reset no register is busy, no slot is pending, in_ready is high and nothing issues.
- R12: Both writeback ports can each clear a different register in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A pair is offered |
| in_ready | output | 1 | The offered pair is taken this clock |
| a_valid | input | 1 | Slot A holds an instruction |
| a_unit | input | 2 | Slot A unit code |
| a_wr | input | 1 | Slot A writes a register |
| a_rd | input | 5 | Slot A destination register |
| a_src1_en | input | 1 | Slot A first source used |
| a_src1 | input | 5 | Slot A first source register |
| a_src2_en | input | 1 | Slot A second source used |
| a_src2 | input | 5 | Slot A second source register |
| b_valid | input | 1 | Slot B holds an instruction |
| b_unit | input | 2 | Slot B unit code |
| b_wr | input | 1 | Slot B writes a register |
| b_rd | input | 5 | Slot B destination register |
| b_src1_en | input | 1 | Slot B first source used |
| b_src1 | input | 5 | Slot B first source register |
| b_src2_en | input | 1 | Slot B second source used |
| b_src2 | input | 5 | Slot B second source register |
| wb_valid | input | 2 | Writeback port valid flags |
| wb_reg | input | 10 | Writeback register numbers, port 0 in the low bits |
| iss_a | output | 1 | Slot A issues this clock |
| iss_a_unit | output | 2 | Unit code of slot A |
| iss_a_wr | output | 1 | Write flag of slot A |
| iss_a_rd | output | 5 | Destination of slot A |
| iss_b | output | 1 | Slot B issues this clock |
| iss_b_unit | output | 2 | Unit code of slot B |
| iss_b_wr | output | 1 | Write flag of slot B |
| iss_b_rd | output | 5 | Destination of slot B |

## Verification
A busy bit left set by mistake shows up as a slot that never issues. That stall is visible on iss_a, iss_b and in_ready in the very clock the bit would have been tested, and it lasts until the watchdog or the next compare catches it. A bit lost too early lets a dependent slot issue one or more clocks before the matching writeback. Per-clock comparison of both issue strobes against a behavioural scoreboard exposes that in the same clock. Pending-slot errors show up at the ports as a wrong in_ready or a repeated or missing issue, also in the same clock. Directed pairs cover pair conflicts and the set-versus-clear collision. A long random run with modelled unit latencies covers the rest.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned UNIT_W = 2;

  typedef enum logic [UNIT_W-1:0] {
    UNIT_INT = 2'd0,
    UNIT_FP  = 2'd1,
    UNIT_BR  = 2'd2,
    UNIT_RSV = 2'd3
  } unit_e;
endpackage

// File: rtl/sb_slot_reg.sv
module sb_slot_reg
  import sb_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              issue_i,
  input  logic              vld_i,
  input  logic [UNIT_W-1:0] unit_i,
  input  logic              wr_i,
  input  logic [RW-1:0]     rd_i,
  input  logic              s1en_i,
  input  logic [RW-1:0]     s1_i,
  input  logic              s2en_i,
  input  logic [RW-1:0]     s2_i,
  output logic              pend_o,
  output logic [UNIT_W-1:0] unit_o,
  output logic              wr_o,
  output logic [RW-1:0]     rd_o,
  output logic              s1en_o,
  output logic [RW-1:0]     s1_o,
  output logic              s2en_o,
  output logic [RW-1:0]     s2_o
);
  logic pend_d, pend_q;

  always_comb begin
    if (load_i) pend_d = vld_i;
    else        pend_d = pend_q & ~issue_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_o <= '0;
      wr_o   <= 1'b0;
      rd_o   <= '0;
      s1en_o <= 1'b0;
      s1_o   <= '0;
      s2en_o <= 1'b0;
      s2_o   <= '0;
    end else if (load_i) begin
      unit_o <= unit_i;
      wr_o   <= wr_i;
      rd_o   <= rd_i;
      s1en_o <= s1en_i;
      s1_o   <= s1_i;
      s2en_o <= s2en_i;
      s2_o   <= s2_i;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/sb_lock_table.sv
module sb_lock_table #(
  parameter int unsigned NREG = 32,
  parameter int unsigned NSET = 2,
  parameter int unsigned NCLR = 2,
  parameter int unsigned RW   = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSET-1:0]          set_en,
  input  logic [NSET-1:0][RW-1:0]  set_reg,
  input  logic [NCLR-1:0]          clr_en,
  input  logic [NCLR-1:0][RW-1:0]  clr_reg,
  output logic [NREG-1:0]          lock_o
);
  logic [NREG-1:0] set_mask, clr_mask, lock_d, lock_q;
  logic            upd;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int c = 0; c < NCLR; c++)
      if (clr_en[c]) clr_mask[clr_reg[c]] = 1'b1;
    for (int s = 0; s < NSET; s++)
      if (set_en[s]) set_mask[set_reg[s]] = 1'b1;
    // a new lock takes precedence over a clear of the same register
    lock_d    = (lock_q & ~clr_mask) | set_mask;
    lock_d[0] = 1'b0;
    upd       = (|set_en) | (|clr_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lock_q <= '0;
    else if (upd) lock_q <= lock_d;
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/sb_reg_hazard.sv
module sb_reg_hazard #(
  parameter int unsigned NREG = 32,
  parameter int unsigned RW   = $clog2(NREG)
) (
  input  logic [NREG-1:0] lock_i,
  input  logic            s1en_i,
  input  logic [RW-1:0]   s1_i,
  input  logic            s2en_i,
  input  logic [RW-1:0]   s2_i,
  input  logic            wre_i,
  input  logic [RW-1:0]   rd_i,
  output logic            src_busy_o,
  output logic            dst_busy_o
);
  always_comb begin
    src_busy_o = (s1en_i & lock_i[s1_i]) | (s2en_i & lock_i[s2_i]);
    dst_busy_o = wre_i & lock_i[rd_i];
  end
endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
  import sb_pkg::*;
#(
  parameter int unsigned RW = 5
) (
  input  logic [1:0]             pend_i,
  input  logic [1:0]             src_busy_i,
  input  logic [1:0]             dst_busy_i,
  input  logic [1:0][UNIT_W-1:0] unit_i,
  input  logic [1:0]             wre_i,
  input  logic [1:0][RW-1:0]     rd_i,
  input  logic                   b_s1en_i,
  input  logic [RW-1:0]          b_s1_i,
  input  logic                   b_s2en_i,
  input  logic [RW-1:0]          b_s2_i,
  output logic [1:0]             go_o,
  output logic                   ready_o
);
  logic a_ok, b_ok, same_unit, b_dep;

  always_comb begin
    a_ok      = pend_i[0] & ~src_busy_i[0] & ~dst_busy_i[0];
    b_ok      = pend_i[1] & ~src_busy_i[1] & ~dst_busy_i[1];
    same_unit = (unit_i[0] == unit_i[1]);
    b_dep     = wre_i[0] & ((b_s1en_i & (b_s1_i == rd_i[0])) |
                            (b_s2en_i & (b_s2_i == rd_i[0])) |
                            (wre_i[1] & (rd_i[1] == rd_i[0])));
    go_o[0]   = a_ok;
    go_o[1]   = b_ok & (~pend_i[0] | (a_ok & ~same_unit & ~b_dep));
    ready_o   = (~pend_i[0] | go_o[0]) & (~pend_i[1] | go_o[1]);
  end
endmodule

// File: rtl/dual_issue_sb.sv
module dual_issue_sb
  import sb_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned NWB  = 2,
  parameter int unsigned RW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              a_valid,
  input  logic [UNIT_W-1:0] a_unit,
  input  logic              a_wr,
  input  logic [RW-1:0]     a_rd,
  input  logic              a_src1_en,
  input  logic [RW-1:0]     a_src1,
  input  logic              a_src2_en,
  input  logic [RW-1:0]     a_src2,
  input  logic              b_valid,
  input  logic [UNIT_W-1:0] b_unit,
  input  logic              b_wr,
  input  logic [RW-1:0]     b_rd,
  input  logic              b_src1_en,
  input  logic [RW-1:0]     b_src1,
  input  logic              b_src2_en,
  input  logic [RW-1:0]     b_src2,
  input  logic [NWB-1:0]    wb_valid,
  input  logic [NWB*RW-1:0] wb_reg,
  output logic              iss_a,
  output logic [UNIT_W-1:0] iss_a_unit,
  output logic              iss_a_wr,
  output logic [RW-1:0]     iss_a_rd,
  output logic              iss_b,
  output logic [UNIT_W-1:0] iss_b_unit,
  output logic              iss_b_wr,
  output logic [RW-1:0]     iss_b_rd
);
  localparam int unsigned NSLOT = 2;

  logic                         accept;
  logic [NSLOT-1:0]             vld_in, wr_in, s1en_in, s2en_in;
  logic [NSLOT-1:0][UNIT_W-1:0] unit_in;
  logic [NSLOT-1:0][RW-1:0]     rd_in, s1_in, s2_in;

  logic [NSLOT-1:0]             pend_q, wr_q, s1en_q, s2en_q, wre;
  logic [NSLOT-1:0][UNIT_W-1:0] unit_q;
  logic [NSLOT-1:0][RW-1:0]     rd_q, s1_q, s2_q;
  logic [NSLOT-1:0]             src_busy, dst_busy, go;
  logic [NREG-1:0]              lock_vec;
  logic [NWB-1:0][RW-1:0]       wb_reg_arr;

  assign accept     = in_valid & in_ready;
  assign wb_reg_arr = wb_reg;

  assign vld_in  = {b_valid, a_valid};
  assign wr_in   = {b_wr, a_wr};
  assign s1en_in = {b_src1_en, a_src1_en};
  assign s2en_in = {b_src2_en, a_src2_en};
  assign unit_in = {b_unit, a_unit};
  assign rd_in   = {b_rd, a_rd};
  assign s1_in   = {b_src1, a_src1};
  assign s2_in   = {b_src2, a_src2};

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    sb_slot_reg #(.RW(RW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .issue_i (go[g]),
      .vld_i   (vld_in[g]),
      .unit_i  (unit_in[g]),
      .wr_i    (wr_in[g]),
      .rd_i    (rd_in[g]),
      .s1en_i  (s1en_in[g]),
      .s1_i    (s1_in[g]),
      .s2en_i  (s2en_in[g]),
      .s2_i    (s2_in[g]),
      .pend_o  (pend_q[g]),
      .unit_o  (unit_q[g]),
      .wr_o    (wr_q[g]),
      .rd_o    (rd_q[g]),
      .s1en_o  (s1en_q[g]),
      .s1_o    (s1_q[g]),
      .s2en_o  (s2en_q[g]),
      .s2_o    (s2_q[g])
    );

    assign wre[g] = wr_q[g] & (rd_q[g] != '0);

    sb_reg_hazard #(.NREG(NREG), .RW(RW)) u_haz (
      .lock_i     (lock_vec),
      .s1en_i     (s1en_q[g]),
      .s1_i       (s1_q[g]),
      .s2en_i     (s2en_q[g]),
      .s2_i       (s2_q[g]),
      .wre_i      (wre[g]),
      .rd_i       (rd_q[g]),
      .src_busy_o (src_busy[g]),
      .dst_busy_o (dst_busy[g])
    );
  end

  sb_issue_ctl #(.RW(RW)) u_ctl (
    .pend_i     (pend_q),
    .src_busy_i (src_busy),
    .dst_busy_i (dst_busy),
    .unit_i     (unit_q),
    .wre_i      (wre),
    .rd_i       (rd_q),
    .b_s1en_i   (s1en_q[1]),
    .b_s1_i     (s1_q[1]),
    .b_s2en_i   (s2en_q[1]),
    .b_s2_i     (s2_q[1]),
    .go_o       (go),
    .ready_o    (in_ready)
  );

  sb_lock_table #(.NREG(NREG), .NSET(NSLOT), .NCLR(NWB), .RW(RW)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (go & wre),
    .set_reg (rd_q),
    .clr_en  (wb_valid),
    .clr_reg (wb_reg_arr),
    .lock_o  (lock_vec)
  );

  assign iss_a      = go[0];
  assign iss_a_unit = unit_q[0];
  assign iss_a_wr   = wr_q[0];
  assign iss_a_rd   = rd_q[0];
  assign iss_b      = go[1];
  assign iss_b_unit = unit_q[1];
  assign iss_b_wr   = wr_q[1];
  assign iss_b_rd   = rd_q[1];
endmodule

// File: rtl/sb_issue_chk.sv
module sb_issue_chk
  import sb_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned RW   = $clog2(NREG)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  a_valid,
  input logic                  b_valid,
  input logic [NREG-1:0]       lock,
  input logic [1:0]            pend,
  input logic [1:0]            go,
  input logic [1:0]            wre,
  input logic [1:0]            s1en,
  input logic [1:0]            s2en,
  input logic [1:0][RW-1:0]    rd,
  input logic [1:0][RW-1:0]    s1,
  input logic [1:0][RW-1:0]    s2,
  input logic [1:0][UNIT_W-1:0] unit
);
  assert_same_unit_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (go[0] && go[1]) |-> (unit[0] != unit[1]));

  assert_lock_set_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go[0] && wre[0]) |=> lock[$past(rd[0])]);

  assert_lock_set_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go[1] && wre[1]) |=> lock[$past(rd[1])]);

  assert_src_free_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go[0] |-> !((s1en[0] && lock[s1[0]]) || (s2en[0] && lock[s2[0]])));

  assert_src_free_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go[1] |-> !((s1en[1] && lock[s1[1]]) || (s2en[1] && lock[s2[1]])));

  assert_pair_dep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go[0] && go[1] && wre[0]) |->
      !((s1en[1] && s1[1] == rd[0]) || (s2en[1] && s2[1] == rd[0])));

  assert_in_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go[1] |-> (go[0] || !pend[0]));

  assert_reg0_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock[0]);

  assert_dst_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (go[0] && wre[0]) |-> !lock[rd[0]]);

  assert_take_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (pend == $past({b_valid, a_valid})));
endmodule

bind dual_issue_sb sb_issue_chk #(.NREG(NREG), .RW(RW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .a_valid  (a_valid),
  .b_valid  (b_valid),
  .lock     (lock_vec),
  .pend     (pend_q),
  .go       (go),
  .wre      (wre),
  .s1en     (s1en_q),
  .s2en     (s2en_q),
  .rd       (rd_q),
  .s1       (s1_q),
  .s2       (s2_q),
  .unit     (unit_q)
);

// File: tb/tb_dual_issue_sb.sv
`timescale 1ns/1ps
module tb_dual_issue_sb;
  localparam int NREG = 32;
  localparam int RW   = 5;
  localparam int NWB  = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, in_valid, in_ready;
  logic a_valid, a_wr, a_src1_en, a_src2_en, b_valid, b_wr, b_src1_en, b_src2_en;
  logic [1:0] a_unit, b_unit;
  logic [RW-1:0] a_rd, a_src1, a_src2, b_rd, b_src1, b_src2;
  logic [NWB-1:0] wb_valid;
  logic [NWB*RW-1:0] wb_reg;
  logic iss_a, iss_a_wr, iss_b, iss_b_wr;
  logic [1:0] iss_a_unit, iss_b_unit;
  logic [RW-1:0] iss_a_rd, iss_b_rd;

  dual_issue_sb dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_valid(a_valid), .a_unit(a_unit), .a_wr(a_wr), .a_rd(a_rd),
    .a_src1_en(a_src1_en), .a_src1(a_src1), .a_src2_en(a_src2_en), .a_src2(a_src2),
    .b_valid(b_valid), .b_unit(b_unit), .b_wr(b_wr), .b_rd(b_rd),
    .b_src1_en(b_src1_en), .b_src1(b_src1), .b_src2_en(b_src2_en), .b_src2(b_src2),
    .wb_valid(wb_valid), .wb_reg(wb_reg),
    .iss_a(iss_a), .iss_a_unit(iss_a_unit), .iss_a_wr(iss_a_wr), .iss_a_rd(iss_a_rd),
    .iss_b(iss_b), .iss_b_unit(iss_b_unit), .iss_b_wr(iss_b_wr), .iss_b_rd(iss_b_rd)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // behavioural scoreboard state
  bit m_pend[2], m_wr[2], m_e1[2], m_e2[2];
  int m_unit[2], m_rd[2], m_s1[2], m_s2[2];
  bit m_lock[NREG];
  int tmr[NREG];

  // stimulus for the next drive
  bit n_valid;
  bit n_vld[2], n_wr[2], n_e1[2], n_e2[2];
  int n_unit[2], n_rd[2], n_s1[2], n_s2[2];
  bit f_en[2];
  int f_reg[2];
  bit auto_wb = 0;
  bit last_acc;
  bit obs_a, obs_b, obs_rdy;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit m_busy(int i);
    return (m_e1[i] && m_lock[m_s1[i]]) || (m_e2[i] && m_lock[m_s2[i]]) ||
           (m_wr[i] && m_rd[i] != 0 && m_lock[m_rd[i]]);
  endfunction

  function automatic int lat(int u);
    return (u == 1) ? 4 : (u == 2) ? 1 : 2;
  endfunction

  task automatic step();
    bit g0, g1, dep, rdy;
    bit wv[2];
    int wr_n[2];
    @(negedge clk);
    g0  = m_pend[0] && !m_busy(0);
    dep = m_wr[0] && m_rd[0] != 0 &&
          ((m_e1[1] && m_s1[1] == m_rd[0]) || (m_e2[1] && m_s2[1] == m_rd[0]) ||
           (m_wr[1] && m_rd[1] == m_rd[0]));
    g1  = m_pend[1] && !m_busy(1) &&
          (!m_pend[0] || (g0 && m_unit[0] != m_unit[1] && !dep));
    rdy = (!m_pend[0] || g0) && (!m_pend[1] || g1);
    chk(iss_a == g0, "R4", "slot A issue", int'(iss_a), int'(g0));
    chk(iss_b == g1, "R6", "slot B issue", int'(iss_b), int'(g1));
    chk(in_ready == rdy, "R10", "in_ready", int'(in_ready), int'(rdy));
    if (g0) chk(int'(iss_a_unit) == m_unit[0] && iss_a_wr == m_wr[0] && int'(iss_a_rd) == m_rd[0],
                "R4", "slot A fields", {iss_a_unit, iss_a_wr, iss_a_rd},
                (m_unit[0] << 6) | (m_wr[0] << 5) | m_rd[0]);
    if (g1) chk(int'(iss_b_unit) == m_unit[1] && iss_b_wr == m_wr[1] && int'(iss_b_rd) == m_rd[1],
                "R4", "slot B fields", {iss_b_unit, iss_b_wr, iss_b_rd},
                (m_unit[1] << 6) | (m_wr[1] << 5) | m_rd[1]);
    obs_a = iss_a; obs_b = iss_b; obs_rdy = in_ready;

    // writebacks: forced ones first, then due results of the delay lines
    for (int p = 0; p < 2; p++) begin wv[p] = f_en[p]; wr_n[p] = f_reg[p]; end
    if (auto_wb)
      for (int r = 1; r < NREG; r++)
        if (tmr[r] == 0) begin
          if (!wv[0])      begin wv[0] = 1; wr_n[0] = r; tmr[r] = -1; end
          else if (!wv[1]) begin wv[1] = 1; wr_n[1] = r; tmr[r] = -1; end
        end
    wb_valid = {wv[1], wv[0]};
    wb_reg   = {RW'(wr_n[1]), RW'(wr_n[0])};

    in_valid = n_valid;
    a_valid = n_vld[0]; a_unit = 2'(n_unit[0]); a_wr = n_wr[0]; a_rd = RW'(n_rd[0]);
    a_src1_en = n_e1[0]; a_src1 = RW'(n_s1[0]); a_src2_en = n_e2[0]; a_src2 = RW'(n_s2[0]);
    b_valid = n_vld[1]; b_unit = 2'(n_unit[1]); b_wr = n_wr[1]; b_rd = RW'(n_rd[1]);
    b_src1_en = n_e1[1]; b_src1 = RW'(n_s1[1]); b_src2_en = n_e2[1]; b_src2 = RW'(n_s2[1]);
    last_acc = n_valid && rdy;

    // model update for the coming edge
    for (int p = 0; p < 2; p++) if (wv[p]) m_lock[wr_n[p]] = 0;
    for (int r = 0; r < NREG; r++) if (tmr[r] > 0) tmr[r]--;
    for (int i = 0; i < 2; i++)
      if ((i == 0 ? g0 : g1) && m_wr[i] && m_rd[i] != 0) begin
        m_lock[m_rd[i]] = 1;
        if (auto_wb) tmr[m_rd[i]] = lat(m_unit[i]);
      end
    if (last_acc) begin
      for (int i = 0; i < 2; i++) begin
        m_pend[i] = n_vld[i]; m_unit[i] = n_unit[i]; m_wr[i] = n_wr[i]; m_rd[i] = n_rd[i];
        m_e1[i] = n_e1[i]; m_s1[i] = n_s1[i]; m_e2[i] = n_e2[i]; m_s2[i] = n_s2[i];
      end
    end else begin
      if (g0) m_pend[0] = 0;
      if (g1) m_pend[1] = 0;
    end
  endtask

  task automatic set_slot(int i, bit vld, int unit, bit wr, int rd, bit e1, int s1, bit e2, int s2);
    n_vld[i] = vld; n_unit[i] = unit; n_wr[i] = wr; n_rd[i] = rd;
    n_e1[i] = e1; n_s1[i] = s1; n_e2[i] = e2; n_s2[i] = s2;
  endtask

  task automatic send();
    n_valid = 1;
    do step(); while (!last_acc);
    n_valid = 0;
  endtask

  task automatic wb_once(int r0, bit use1, int r1);
    f_en[0] = 1; f_reg[0] = r0; f_en[1] = use1; f_reg[1] = r1;
    step();
    f_en[0] = 0; f_en[1] = 0;
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) begin m_lock[r] = 0; tmr[r] = -1; end
    for (int i = 0; i < 2; i++) begin
      m_pend[i] = 0; m_wr[i] = 0; m_e1[i] = 0; m_e2[i] = 0;
      m_unit[i] = 0; m_rd[i] = 0; m_s1[i] = 0; m_s2[i] = 0;
      set_slot(i, 0, 0, 0, 0, 0, 0, 0, 0);
      f_en[i] = 0; f_reg[i] = 0;
    end
    n_valid = 0;
    rst_n = 0; in_valid = 0; wb_valid = '0; wb_reg = '0;
    a_valid = 0; a_unit = 0; a_wr = 0; a_rd = 0; a_src1_en = 0; a_src1 = 0; a_src2_en = 0; a_src2 = 0;
    b_valid = 0; b_unit = 0; b_wr = 0; b_rd = 0; b_src1_en = 0; b_src1 = 0; b_src2_en = 0; b_src2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11: idle after reset
    step();
    chk(obs_rdy == 1 && obs_a == 0 && obs_b == 0, "R11", "reset state",
        {obs_rdy, obs_a, obs_b}, 3'b100);

    // R1: integer + floating point pair dual issues
    set_slot(0, 1, 0, 1, 1, 1, 0, 0, 0);
    set_slot(1, 1, 1, 1, 2, 0, 0, 0, 0);
    send(); step();
    chk(obs_a && obs_b, "R1", "mixed-unit pair", {obs_a, obs_b}, 3);

    // R12: both ports clear in one clock, then readers of r1 and r2 go together
    wb_once(1, 1, 2);
    set_slot(0, 1, 0, 0, 0, 1, 1, 0, 0);
    set_slot(1, 1, 1, 0, 0, 1, 2, 0, 0);
    send(); step();
    chk(obs_a && obs_b, "R12", "dual clear", {obs_a, obs_b}, 3);

    // R2: same unit splits over two clocks
    set_slot(0, 1, 0, 0, 0, 0, 0, 0, 0);
    set_slot(1, 1, 0, 0, 0, 0, 0, 0, 0);
    send(); step();
    chk(obs_a && !obs_b, "R2", "same unit first clock", {obs_a, obs_b}, 2);
    step();
    chk(!obs_a && obs_b, "R2", "same unit second clock", {obs_a, obs_b}, 1);

    // R5 and R3: B reads A's destination
    set_slot(0, 1, 0, 1, 5, 0, 0, 0, 0);
    set_slot(1, 1, 1, 0, 0, 1, 5, 0, 0);
    send(); step();
    chk(obs_a && !obs_b, "R5", "intra-pair dependency", {obs_a, obs_b}, 2);
    step();
    chk(!obs_b, "R3", "reader waits on lock", obs_b, 0);
    wb_once(5, 0, 0);
    step();
    chk(obs_b, "R3", "reader after writeback", obs_b, 1);

    // R6: older held keeps younger held
    set_slot(0, 1, 0, 1, 6, 0, 0, 0, 0);
    set_slot(1, 0, 0, 0, 0, 0, 0, 0, 0);
    send(); step();
    set_slot(0, 1, 0, 0, 0, 1, 6, 0, 0);
    set_slot(1, 1, 1, 0, 0, 0, 0, 0, 0);
    send(); step();
    chk(!obs_a && !obs_b, "R6", "in-order hold", {obs_a, obs_b}, 0);
    chk(!obs_rdy, "R10", "ready low while held", obs_rdy, 0);
    wb_once(6, 0, 0);
    step();
    chk(obs_a && obs_b, "R4", "retry after clear", {obs_a, obs_b}, 3);

    // R7: register 0 never blocks
    set_slot(0, 1, 0, 1, 0, 1, 0, 1, 0);
    set_slot(1, 1, 1, 1, 0, 1, 0, 0, 0);
    send(); step();
    chk(obs_a && obs_b, "R7", "r0 write pair", {obs_a, obs_b}, 3);
    set_slot(0, 1, 0, 0, 0, 1, 0, 0, 0);
    set_slot(1, 1, 1, 0, 0, 0, 0, 1, 0);
    send(); step();
    chk(obs_a && obs_b, "R7", "r0 readers", {obs_a, obs_b}, 3);

    // R8: writeback of r7 in the clock its new writer issues
    set_slot(0, 1, 0, 1, 7, 0, 0, 0, 0);
    set_slot(1, 0, 0, 0, 0, 0, 0, 0, 0);
    send();
    wb_once(7, 0, 0);
    set_slot(0, 1, 1, 0, 0, 1, 7, 0, 0);
    send(); step();
    chk(!obs_a, "R8", "set wins over clear", obs_a, 0);
    wb_once(7, 0, 0);
    step();
    chk(obs_a, "R3", "reader of r7 after writeback", obs_a, 1);

    // R9: destination already busy
    set_slot(0, 1, 0, 1, 8, 0, 0, 0, 0);
    send(); step();
    set_slot(0, 1, 1, 1, 8, 0, 0, 0, 0);
    send(); step();
    chk(!obs_a, "R9", "busy destination holds", obs_a, 0);
    wb_once(8, 0, 0);
    step();
    chk(obs_a, "R9", "destination freed", obs_a, 1);
    wb_once(8, 0, 0);

    // R10: invalid slot B is never issued
    set_slot(0, 1, 0, 0, 0, 0, 0, 0, 0);
    set_slot(1, 0, 0, 0, 0, 1, 0, 0, 0);
    send(); step();
    chk(obs_a && !obs_b && obs_rdy, "R10", "invalid slot ignored",
        {obs_a, obs_b, obs_rdy}, 3'b101);

    // random traffic with modelled unit latencies
    auto_wb = 1;
    for (int k = 0; k < 4000; k++) begin
      n_valid = ($urandom % 4) != 0;
      for (int i = 0; i < 2; i++)
        set_slot(i, (i == 0) ? (($urandom % 8) != 0) : (($urandom % 4) != 0),
                 $urandom % 3, $urandom % 2, $urandom % 8,
                 $urandom % 2, $urandom % 8, $urandom % 2, $urandom % 8);
      step();
    end
    n_valid = 0;
    repeat (20) step();

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule